// File: doc/BRIEF.md
# Multi-format stereo audio serial receiver

This block is a slave receiver for stereo audio carried on up to three serial data lines. All lines share one bit clock and one frame clock, both driven from outside. The block runs directly in the bit-clock domain. Each data line is sampled on the rising edge of the bit clock. Sample words are sent most significant bit first and use two's complement coding. The block turns every completed frame into a parallel left and right word for each line.

A two-bit format input selects how the sample sits inside each half of the frame:

| Code | Format |
|------|--------|
| 00 | right-justified, 20-bit |
| 01 | right-justified, 24-bit |
| 10 | left-justified, 24-bit |
| 11 | I2S |

The block finds the sample position inside each half-frame from the format alone, counting bit clocks from each frame-clock edge. A 20-bit sample is sign-extended to the 24-bit output width. When both halves of a frame are complete, the outputs of all lines update together and a single-cycle strobe is raised.

Top module: `audrx_rx`

## Requirements
- R1: In format 10, frame clock high is the left channel. The MSB is the bit sampled on the first rising edge that sees the frame clock at its new level. Exactly 24 bits are taken, and any later bits of that half-frame have no effect on the output.
- R2: In format 11, frame clock low is the left channel. The MSB is the bit sampled on the second rising edge after the frame clock changes. With 24-bit half-frames, the LSB is taken on the first edge of the following half.
- R3: In format 01, frame clock high is the left channel. The sample is the last 24 bits before the next frame-clock change, and earlier bits have no effect. A 16- to 20-bit word sent with zeroed low bits comes out with those bits zero.
- R4: In format 00, frame clock high is the left channel. The sample is the last 20 bits before the next frame-clock change. It is sign-extended from bit 19 into bits 23..20, and earlier bits have no effect.
- R5: valid_o is high for exactly one cycle per frame, in the cycle after the last bit of the right channel is sampled. All left and right outputs change only in that cycle and hold their values otherwise.
- R6: Each of the three data lines is decoded independently with the same timing. Line n occupies bits 24n+23..24n of left_o and right_o.
- R7: After reset, all outputs are zero and valid_o is low. A half-frame that was not opened by a frame-clock change seen after reset is discarded. The first strobe carries the first frame whose left and right halves were both seen in full.
- R8: Half-frames from 24 bit clocks up to any longer length decode correctly in every format.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock; all sampling and state changes occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt | input | 2 | Format code (00 RJ20, 01 RJ24, 10 LJ, 11 I2S) |
| lrck | input | 1 | Frame clock selecting left or right half |
| sdata | input | LINES | Serial data lines, one bit per line |
| left_o | output | LINES*24 | Left samples, line n at bits 24n+23..24n |
| right_o | output | LINES*24 | Right samples, line n at bits 24n+23..24n |
| valid_o | output | 1 | One-cycle strobe when a new frame is on the outputs |

## Verification
The assertions check several properties on every cycle:
- The outputs hold steady between strobes.
- Two strobes never fall in back-to-back cycles.
- No strobe appears before the frame-clock history has been primed.
- The bit counter stays within its saturation bound.
- Every 20-bit right-justified capture is properly sign-extended.

The other requirements can only be shown by the bench's scenarios, because they depend on where bits sit in the serial stream. These include:
- the exact MSB and LSB positions for each format;
- the ignored filler bits;
- the one-edge I2S delay when the LSB spills into the next half;
- the three-line independence;
- dropping a partial first frame when the stream begins mid-half.

// File: rtl/audrx_pkg.sv
package audrx_pkg;

    typedef enum logic [1:0] {
        FMT_RJ20 = 2'b00,
        FMT_RJ24 = 2'b01,
        FMT_LJ   = 2'b10,
        FMT_I2S  = 2'b11
    } fmt_e;

    localparam int unsigned SAMPLE_W = 24;
    localparam int unsigned SHORT_W  = 20;

endpackage

// File: rtl/audrx_frame_track.sv
module audrx_frame_track
    import audrx_pkg::*;
#(
    parameter int unsigned WORD_W = SAMPLE_W
) (
    input  logic bclk,
    input  logic rst_n,
    input  fmt_e fmt,
    input  logic lrck,
    output logic shift_en,
    output logic end_left,
    output logic end_right,
    output logic valid
);

    localparam int unsigned CW = $clog2(WORD_W + 1);

    typedef struct packed {
        logic          lrck;
        logic          left;
        logic [1:0]    prime;
        logic [CW-1:0] k;
        logic          synced;
        logic          left_ok;
        logic          valid;
    } trk_s;

    trk_s trk_d, trk_q;
    logic is_left;
    logic edge_now;
    logic primed;
    logic rj_fmt;

    always_comb begin
        trk_d    = trk_q;
        // I2S: delay the frame clock by one bit and invert it, so the
        // word then lines up as left-justified on the delayed clock.
        is_left  = (fmt == FMT_I2S) ? ~trk_q.lrck : lrck;
        primed   = (trk_q.prime == 2'd2);
        edge_now = primed && (is_left != trk_q.left);
        rj_fmt   = (fmt == FMT_RJ20) || (fmt == FMT_RJ24);

        end_left  = edge_now && trk_q.left && trk_q.synced;
        end_right = edge_now && !trk_q.left && trk_q.synced && trk_q.left_ok;
        shift_en  = rj_fmt || edge_now || (trk_q.k < CW'(WORD_W));

        trk_d.lrck = lrck;
        trk_d.left = is_left;
        if (!primed) begin
            trk_d.prime = trk_q.prime + 2'd1;
        end
        if (edge_now) begin
            trk_d.k = CW'(1);
        end else if (trk_q.k < CW'(WORD_W)) begin
            trk_d.k = trk_q.k + CW'(1);
        end
        if (edge_now) begin
            trk_d.synced = 1'b1;
        end
        if (end_left) begin
            trk_d.left_ok = 1'b1;
        end
        trk_d.valid = end_right;
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign valid = trk_q.valid;

    AST_K_BOUND: assert property (@(posedge bclk) disable iff (!rst_n)
        trk_q.k <= CW'(WORD_W)); // R8

    AST_VALID_SPACED: assert property (@(posedge bclk) disable iff (!rst_n)
        trk_q.valid |=> !trk_q.valid); // R5

    AST_NO_EARLY_VALID: assert property (@(posedge bclk) disable iff (!rst_n)
        (trk_q.prime != 2'd2) |-> !trk_d.valid); // R7

endmodule

// File: rtl/audrx_lane.sv
module audrx_lane
    import audrx_pkg::*;
#(
    parameter int unsigned WORD_W = SAMPLE_W,
    parameter int unsigned NARROW = SHORT_W
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  fmt_e              fmt,
    input  logic              din,
    input  logic              shift_en,
    input  logic              end_left,
    input  logic              end_right,
    output logic [WORD_W-1:0] left_w,
    output logic [WORD_W-1:0] right_w
);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] lhold;
        logic [WORD_W-1:0] lout;
        logic [WORD_W-1:0] rout;
    } lane_s;

    lane_s ln_d, ln_q;
    logic [WORD_W-1:0] word;

    always_comb begin
        ln_d = ln_q;
        if (fmt == FMT_RJ20) begin
            word = {{(WORD_W-NARROW){ln_q.sh[NARROW-1]}}, ln_q.sh[NARROW-1:0]};
        end else begin
            word = ln_q.sh;
        end
        if (shift_en) begin
            ln_d.sh = {ln_q.sh[WORD_W-2:0], din};
        end
        if (end_left) begin
            ln_d.lhold = word;
        end
        if (end_right) begin
            ln_d.lout = ln_q.lhold;
            ln_d.rout = word;
        end
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign left_w  = ln_q.lout;
    assign right_w = ln_q.rout;

    AST_SIGN_EXT: assert property (@(posedge bclk) disable iff (!rst_n)
        (end_right && fmt == FMT_RJ20) |=>
        (ln_q.rout[WORD_W-1:NARROW-1] == '0 || ln_q.rout[WORD_W-1:NARROW-1] == '1)); // R4

endmodule

// File: rtl/audrx_rx.sv
module audrx_rx
    import audrx_pkg::*;
#(
    parameter int unsigned LINES = 3
) (
    input  logic                       bclk,
    input  logic                       rst_n,
    input  logic [1:0]                 fmt,
    input  logic                       lrck,
    input  logic [LINES-1:0]           sdata,
    output logic [LINES*SAMPLE_W-1:0]  left_o,
    output logic [LINES*SAMPLE_W-1:0]  right_o,
    output logic                       valid_o
);

    fmt_e fmt_s;
    logic shift_en;
    logic end_left;
    logic end_right;

    assign fmt_s = fmt_e'(fmt);

    audrx_frame_track #(.WORD_W(SAMPLE_W)) u_track (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .fmt       (fmt_s),
        .lrck      (lrck),
        .shift_en  (shift_en),
        .end_left  (end_left),
        .end_right (end_right),
        .valid     (valid_o)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_lane
        audrx_lane #(.WORD_W(SAMPLE_W), .NARROW(SHORT_W)) u_lane (
            .bclk      (bclk),
            .rst_n     (rst_n),
            .fmt       (fmt_s),
            .din       (sdata[g]),
            .shift_en  (shift_en),
            .end_left  (end_left),
            .end_right (end_right),
            .left_w    (left_o[g*SAMPLE_W +: SAMPLE_W]),
            .right_w   (right_o[g*SAMPLE_W +: SAMPLE_W])
        );
    end

    AST_OUT_HOLD: assert property (@(posedge bclk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_o) && $stable(right_o))); // R5

endmodule

// File: tb/sim_audrx_rx.sv
module sim_audrx_rx;

    localparam int CLK_PERIOD = 10;
    localparam int LINES      = 3;
    localparam int NF         = 3;
    localparam int WD_LIMIT   = 100000;

    // {fmt, half length, left base, right base}
    localparam int NV = 9;
    localparam logic [57:0] VEC [NV] = '{
        {2'b10, 8'd32, 24'h123456, 24'hFEDCBA},
        {2'b10, 8'd24, 24'h800001, 24'h7FFFFE},
        {2'b11, 8'd32, 24'hA5C3E1, 24'h0F1E2D},
        {2'b11, 8'd24, 24'h400001, 24'hC00003},
        {2'b01, 8'd32, 24'h9ABCDE, 24'h135791},
        {2'b01, 8'd25, 24'hABCD00, 24'h012300},
        {2'b00, 8'd32, 24'h087654, 24'h0FFFFF},
        {2'b00, 8'd24, 24'h012345, 24'h07FFF0},
        {2'b00, 8'd40, 24'hF80000, 24'h000001}
    };

    logic                    bclk = 1'b0;
    logic                    rst_n;
    logic [1:0]              fmt;
    logic                    lrck;
    logic [LINES-1:0]        sdata;
    logic [LINES*24-1:0]     left_o;
    logic [LINES*24-1:0]     right_o;
    logic                    valid_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #(CLK_PERIOD/2) bclk = ~bclk;

    audrx_rx #(.LINES(LINES)) u0 (
        .bclk    (bclk),
        .rst_n   (rst_n),
        .fmt     (fmt),
        .lrck    (lrck),
        .sdata   (sdata),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (valid_o)
    );

    always @(posedge bclk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic logic [23:0] samp(logic [23:0] base, int fr, int ln);
        return base + 24'(fr) * 24'h010203 + 24'(ln) * 24'h111111;
    endfunction

    function automatic logic [23:0] expv(logic [1:0] f, logic [23:0] v);
        return (f == 2'b00) ? {{4{v[19]}}, v[19:0]} : v;
    endfunction

    function automatic logic lr_at(logic [1:0] f, int h, int j);
        logic left_half;
        left_half = ((j / h) % 2) == 0;
        return (f == 2'b11) ? !left_half : left_half;
    endfunction

    function automatic logic bit_at(logic [1:0] f, int h, int j, int ln,
                                    logic [23:0] lb, logic [23:0] rb);
        int q;
        int fr;
        int p;
        int pp;
        int st;
        logic [23:0] v;
        q = (f == 2'b11) ? j - 1 : j;
        if (q < 0) return 1'b1;
        fr = q / (2 * h);
        p  = q % (2 * h);
        if (fr >= NF) return 1'b0;
        pp = p % h;
        v  = (p >= h) ? samp(rb, fr, ln) : samp(lb, fr, ln);
        if (f == 2'b10 || f == 2'b11) begin
            return (pp < 24) ? v[23 - pp] : 1'b1;
        end else if (f == 2'b01) begin
            st = h - 24;
            return (pp >= st) ? v[23 - (pp - st)] : 1'b1;
        end else begin
            st = h - 20;
            return (pp >= st) ? v[19 - (pp - st)] : 1'b1;
        end
    endfunction

    task automatic chk(input logic ok, input string req,
                       input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] f, input int h, input logic [23:0] lb,
                       input logic [23:0] rb, input int skip, input string req);
        int nv = 0;
        int total;
        logic [23:0] el;
        logic [23:0] er;
        total = 2 * h * NF + h + 2;
        @(negedge bclk);
        rst_n = 1'b0;
        fmt   = f;
        lrck  = 1'b0;
        sdata = '0;
        repeat (3) @(posedge bclk);
        @(negedge bclk);
        // R7: reset state
        chk(valid_o == 1'b0, "R7 reset valid", 24'(valid_o), 24'h0);
        chk(left_o == '0 && right_o == '0, "R7 reset outputs",
            left_o[23:0] | right_o[23:0], 24'h0);
        rst_n = 1'b1;
        for (int j = skip; j < total; j++) begin
            lrck = lr_at(f, h, j);
            for (int ln = 0; ln < LINES; ln++) begin
                sdata[ln] = bit_at(f, h, j, ln, lb, rb);
            end
            @(negedge bclk);
            if (valid_o) begin
                nv++;
                for (int ln = 0; ln < LINES; ln++) begin
                    el = expv(f, samp(lb, nv, ln));
                    er = expv(f, samp(rb, nv, ln));
                    // R6: every line decoded with the same timing
                    chk(left_o[ln*24 +: 24] == el,
                        $sformatf("%s R6 line%0d left frame%0d", req, ln, nv),
                        left_o[ln*24 +: 24], el);
                    chk(right_o[ln*24 +: 24] == er,
                        $sformatf("%s R6 line%0d right frame%0d", req, ln, nv),
                        right_o[ln*24 +: 24], er);
                end
            end
        end
        // R5: one strobe per complete frame; R7: partial first frame dropped
        chk(nv == NF - 1, $sformatf("%s R5 R7 strobe count", req), 24'(nv), 24'(NF - 1));
        // R5: outputs held after the final strobe
        el = expv(f, samp(lb, NF - 1, 0));
        chk(left_o[23:0] == el, $sformatf("%s R5 hold", req), left_o[23:0], el);
    endtask

    initial begin
        rst_n = 1'b0;
        fmt   = 2'b10;
        lrck  = 1'b0;
        sdata = '0;
        for (int i = 0; i < NV; i++) begin
            string rq;
            case (VEC[i][57:56])
                2'b10:   rq = "R1";
                2'b11:   rq = "R2";
                2'b01:   rq = "R3";
                default: rq = "R4";
            endcase
            if (VEC[i][55:48] == 8'd24 || VEC[i][55:48] == 8'd25) rq = {rq, " R8"};
            run(VEC[i][57:56], int'(VEC[i][55:48]), VEC[i][47:24], VEC[i][23:0], 0, rq);
        end
        // R7: stream entered in the middle of a left half
        run(2'b10, 32, 24'h55AA33, 24'hCC1177, 13, "R7 mid-left");
        // R7: stream entered inside a right half
        run(2'b11, 28, 24'h3C3C3C, 24'hE0E0E1, 28 + 5, "R7 mid-right");
        // R7: right-justified stream entered just before a change
        run(2'b00, 26, 24'h0ABCDE, 24'h080000, 24, "R7 R4 late start");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule